// File: doc/BRIEF.md
# Reversible Digit Sequence Display Counter

The block walks a fixed list of eight decimal digits, forward or backward, and shows the digit at the current position on a single seven-segment display. A three-bit position register is the state. It wraps modulo 8 and moves one place per step. The direction input sets whether a step moves up or down. Position 0 always shows the digit 0. Positions 1 to 7 show seven digits that are fixed by a parameter when the block is built.

The position is kept apart from the digit it shows. A digit that appears twice in the list therefore does not stall the walk. A prescaler divides the 50 MHz system clock to make a single-cycle step enable once per second. Every register runs on the system clock, and no clock is derived inside the block. The division ratio is a parameter, and a bench can make it small. The selected BCD digit goes through a registered decoder to active-low segment lines.

Top module: `digit_seq_display`

## Requirements
- R1: While rst_ni is low, state_o is 0, digit_o is 0 and seg_no is 7'h40 (the pattern for digit 0).
- R2: At a step enable with up_i = 1, state_o becomes (state + 1) mod 8, so 7 is followed by 0.
- R3: At a step enable with up_i = 0, state_o becomes (state - 1) mod 8, so 0 is followed by 7.
- R4: state_o does not change on any clock cycle without a step enable.
- R5: One step enable occurs every DIV_COUNT system clock cycles, with a default of 50,000,000, which is 1 Hz from 50 MHz. After reset is released, the first step occurs on the DIV_COUNT-th rising edge.
- R6: digit_o is 0 when state_o is 0. For state_o = k with k from 1 to 7, digit_o is the 4-bit field DIGITS[4k-1:4k-4], and the same value may appear in several fields.
- R7: seg_no is active-low with bit order {g,f,e,d,c,b,a}. It is registered one clock after digit_o. Digits 0 to 9 give 40,79,24,30,19,12,02,78,00,10 in hex.
- R8: A digit value above 9 drives seg_no to 7'h7F, with all segments off.
- R9: The level of up_i is only used at a step enable. Changing it between enables leaves state_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, 50 MHz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Step direction: 1 counts up, 0 counts down |
| seg_no | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| state_o | output | 3 | Current sequence position |
| digit_o | output | 4 | BCD digit selected by the position |

## Verification
The assertions check several rules on every cycle:
- the step enable is never high two cycles in a row;
- the position holds when there is no step;
- a step moves the position by plus or minus one mod 8, according to up_i;
- position 0 shows digit 0;
- a digit above 9 blanks the segments on the next cycle.

Only the bench scenarios can show the rest:
- the exact step period after reset;
- wrap-around in both directions;
- that a repeated digit in the list still advances;
- the full segment pattern for every position;
- that a direction change has no effect until the next step.

// File: rtl/digit_disp_pkg.sv
package digit_disp_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;
  localparam seg_t SEG_BLANK_N = 7'h7F;
  localparam seg_t SEG_ZERO_N  = 7'h40;
endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
  parameter int unsigned DIV_COUNT = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int unsigned CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = (cnt_q == LAST);

  generate
    if (DIV_COUNT > 1) begin : g_chk
      assert_step_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/updown_state.sv
module updown_state #(
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          up_i,
  output logic [SW-1:0] state_o
);
  logic [SW-1:0] state_q;

  // modulo 2**SW wrap falls out of the register width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (step_i) state_q <= up_i ? state_q + 1'b1 : state_q - 1'b1;
  end

  assign state_o = state_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
  assert_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && up_i) |=> (state_q == SW'($past(state_q) + 1'b1)));
  assert_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !up_i) |=> (state_q == SW'($past(state_q) - 1'b1)));
endmodule

// File: rtl/digit_lookup.sv
module digit_lookup
  import digit_disp_pkg::*;
#(
  parameter int unsigned SW = 3,
  localparam int unsigned NS = 1 << SW,
  parameter logic [(NS-1)*4-1:0] DIGITS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] state_i,
  output bcd_t          digit_o
);
  bcd_t table_w [NS];

  // position 0 is pinned to zero, the rest come from the parameter
  assign table_w[0] = '0;
  generate
    for (genvar k = 1; k < NS; k++) begin : g_tab
      assign table_w[k] = DIGITS[4*k-1 -: 4];
    end
  endgenerate

  assign digit_o = table_w[state_i];

  assert_zero_pos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == '0) |-> (digit_o == 4'd0));
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import digit_disp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  bcd_t digit_i,
  output seg_t seg_no
);
  seg_t lit;  // active-high {g,f,e,d,c,b,a}
  seg_t seg_q;

  always_comb begin
    unique case (digit_i)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= SEG_ZERO_N;
    else         seg_q <= ~lit;
  end

  assign seg_no = seg_q;

  assert_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_i > 4'd9) |=> (seg_no == SEG_BLANK_N));
endmodule

// File: rtl/digit_seq_display.sv
module digit_seq_display
  import digit_disp_pkg::*;
#(
  parameter int unsigned DIV_COUNT = 50_000_000,
  parameter logic [27:0] DIGITS = {4'd9, 4'd1, 4'd0, 4'd5, 4'd5, 4'd6, 4'd2}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       up_i,
  output logic [6:0] seg_no,
  output logic [2:0] state_o,
  output logic [3:0] digit_o
);
  localparam int unsigned SW = 3;

  logic step;

  step_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_o(step)
  );

  updown_state #(.SW(SW)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .up_i(up_i), .state_o(state_o)
  );

  digit_lookup #(.SW(SW), .DIGITS(DIGITS)) u_lut (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_o), .digit_o(digit_o)
  );

  seg_decoder u_seg (
    .clk_i(clk_i), .rst_ni(rst_ni), .digit_i(digit_o), .seg_no(seg_no)
  );
endmodule

// File: tb/digit_seq_display_bench.sv
`timescale 1ns/1ps
module digit_seq_display_bench;
  localparam int DIV = 4;
  localparam logic [27:0] DIGS = {4'd9, 4'd1, 4'd12, 4'd5, 4'd5, 4'd6, 4'd2};
  localparam logic [3:0] EXP_DIG [8] = '{4'd0, 4'd2, 4'd6, 4'd5, 4'd5, 4'd12, 4'd1, 4'd9};
  localparam int NV = 20;
  // {direction, expected state after the step}
  localparam logic [3:0] VEC [NV] = '{
    4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110, 4'b1111, 4'b1000,
    4'b0111, 4'b0110, 4'b0101, 4'b0100, 4'b0011, 4'b0010, 4'b0001, 4'b0000,
    4'b0111, 4'b1000, 4'b0111, 4'b0110};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b1;
  logic [6:0] seg;
  logic [2:0] st;
  logic [3:0] dig;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  digit_seq_display #(.DIV_COUNT(DIV), .DIGITS(DIGS)) u_digit_seq_display (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .seg_no(seg), .state_o(st), .digit_o(dig)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] d);
    case (d)
      4'd0: return 7'h40;  4'd1: return 7'h79;  4'd2: return 7'h24;
      4'd3: return 7'h30;  4'd4: return 7'h19;  4'd5: return 7'h12;
      4'd6: return 7'h02;  4'd7: return 7'h78;  4'd8: return 7'h00;
      4'd9: return 7'h10;  default: return 7'h7F;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    logic [2:0] prev;
    @(negedge clk);
    chk("R1 reset state", st, 0);
    chk("R1 reset digit", dig, 0);
    chk("R1 reset seg", seg, 7'h40);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev = 3'd0;
    for (int i = 0; i < NV; i++) begin
      up = VEC[i][3];  // changed right after the previous step
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      chk("R4 R9 hold between steps", st, prev);
      if (EXP_DIG[prev] > 9) chk("R8 blank seg", seg, 7'h7F);
      else                   chk("R7 seg pattern", seg, exp_seg(EXP_DIG[prev]));
      @(posedge clk);
      @(negedge clk);
      if (VEC[i][3]) chk("R2 R5 step up", st, VEC[i][2:0]);
      else           chk("R3 R5 step down", st, VEC[i][2:0]);
      chk("R6 digit lookup", dig, EXP_DIG[VEC[i][2:0]]);
      prev = VEC[i][2:0];
    end
    // asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset state", st, 0);
    chk("R1 async reset seg", seg, 7'h40);
    @(negedge clk);
    up = 1'b1;
    rst_n = 1'b1;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 no step before period", st, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 first step after reset", st, 1);
    chk("R6 digit state1", dig, 2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule